// File: doc/BRIEF.md
# Two-Way FIFO Write-Back Data Cache

This block is a small data cache placed between a processor load/store port and a 16-word backing memory. It holds four single-word lines, organised as two sets of two ways. The set is picked by the low address bit, and the remaining three address bits form the tag. Inside a set, the line that has been resident longest is the one replaced. Read hits do not change that order. Stores update only the cached copy. Memory sees the data only when a dirty line is chosen as a victim.

The processor side and the memory side both use a hold-until-ready handshake. A requester raises `*_req` with stable address and data and keeps it raised until the responder returns a one-cycle `*_ready` pulse. While `cache_en` is low, accepted requests go straight to memory and no line is allocated or examined. Raising `flush_req` makes the cache walk its lines in index order and write back every valid dirty line. It then invalidates all lines and pulses `flush_done`.

Top module: `fifo_wb_cache`

## Requirements
- R1: After reset all lines are invalid, `cpu_ready`, `flush_done` and `mem_req` are low, and way 0 of each set is the first way filled.
- R2: A word address maps to set `addr[0]` with tag `addr[3:1]`. Two addresses of one set with different tags can be resident together.
- R3: A read hit returns the cached word with `cpu_ready` high in the cycle after the request is accepted, and raises no memory request.
- R4: On a miss in a full set, the victim is the line filled earliest in that set. Read hits in between do not change the choice.
- R5: A store hit updates only the cached word, marks it dirty and performs no memory write.
- R6: A miss whose victim is valid and dirty first writes the victim word to its own address, then reads the requested word. A clean or invalid victim causes no write.
- R7: A store miss allocates the line: the word is read from memory, replaced by the store data, and the line is marked dirty.
- R8: With `cache_en` low, a read returns the memory word and a write updates memory directly. Cached lines and their replacement order are left untouched.
- R9: A flush writes back each valid dirty line in line-index order (index = set*2 + way). It then invalidates every line and gives a one-cycle `flush_done` pulse, after which memory holds every written value.
- R10: When `flush_req` and `cpu_req` are both present in an idle cycle, the flush completes first. The request is then served against the emptied cache.
- R11: `cpu_ready` and `flush_done` are single-cycle pulses. `mem_req` and its address, direction and write data stay stable until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| cache_en | input | 1 | 1 = cached access, 0 = direct to memory |
| flush_req | input | 1 | Write back dirty lines, then invalidate all |
| flush_done | output | 1 | One-cycle pulse when a flush ends |
| mem_req | output | 1 | Memory request, held until `mem_ready` |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | One-cycle memory completion pulse |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ready` |

## Verification
A flush command and a processor request can arrive in the same idle cycle. The bench provokes this by raising both together on the same falling edge while dirty lines are resident. It judges the result in three ways:
- `flush_done` must appear before `cpu_ready`.
- The memory write log must show the dirty lines in index order.
- The request must then behave as a miss, with more than one cycle of latency, and return the value the reference model predicts after the write-backs.

// File: rtl/cwb_pkg.sv
package cwb_pkg;

    // Controller phases of the cache
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_BYPASS,
        ST_FLUSH
    } state_t;

endpackage

// File: rtl/cwb_line_store.sv
// Line array: valid/dirty/tag/data per line plus a per-set FIFO pointer.
// Line index = set * WAYS + way. WAYS and SETS are powers of two.
module cwb_line_store #(
    parameter int SETS   = 2,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int LINES  = SETS * WAYS,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SET_W-1:0]              rd_set,
    output logic [WAYS-1:0]               rd_valid,
    output logic [WAYS-1:0]               rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]    rd_tag,
    output logic [WAYS-1:0][DATA_W-1:0]   rd_data,
    output logic [WAY_W-1:0]              rd_ptr,
    input  logic [LINE_W-1:0]             fl_idx,
    output logic                          fl_valid,
    output logic                          fl_dirty,
    output logic [TAG_W-1:0]              fl_tag,
    output logic [DATA_W-1:0]             fl_data,
    input  logic                          wr_en,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic                          wr_dirty,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          ptr_adv,
    input  logic                          clr_all
);

    typedef struct packed {
        logic [LINES-1:0]               valid;
        logic [LINES-1:0]               dirty;
        logic [LINES-1:0][TAG_W-1:0]    tag;
        logic [LINES-1:0][DATA_W-1:0]   data;
        logic [SETS-1:0][WAY_W-1:0]     ptr;
    } store_t;

    store_t s_d, s_q;
    logic [LINE_W-1:0] wr_line;

    assign wr_line = {rd_set, wr_way};

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.valid[wr_line] = 1'b1;
            s_d.dirty[wr_line] = wr_dirty;
            s_d.tag[wr_line]   = wr_tag;
            s_d.data[wr_line]  = wr_data;
        end
        if (ptr_adv) begin
            s_d.ptr[rd_set] = (s_q.ptr[rd_set] == WAY_W'(WAYS - 1)) ? '0
                                                                    : s_q.ptr[rd_set] + 1'b1;
        end
        if (clr_all) begin
            s_d.valid = '0;
            s_d.dirty = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign rd_valid[w] = s_q.valid[{rd_set, WAY_W'(w)}];
        assign rd_dirty[w] = s_q.dirty[{rd_set, WAY_W'(w)}];
        assign rd_tag[w]   = s_q.tag[{rd_set, WAY_W'(w)}];
        assign rd_data[w]  = s_q.data[{rd_set, WAY_W'(w)}];
    end

    assign rd_ptr   = s_q.ptr[rd_set];
    assign fl_valid = s_q.valid[fl_idx];
    assign fl_dirty = s_q.dirty[fl_idx];
    assign fl_tag   = s_q.tag[fl_idx];
    assign fl_data  = s_q.data[fl_idx];

endmodule

// File: rtl/cwb_hit_find.sv
// Tag compare across the ways of one set.
module cwb_hit_find #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 3,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           key,
    output logic                       hit,
    output logic [WAY_W-1:0]           way
);

    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid[w] && tags[w] == key && !hit) begin
                hit = 1'b1;
                way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/fifo_wb_cache.sv
module fifo_wb_cache
    import cwb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int SETS   = 2,
    parameter int WAYS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              cache_en,
    input  logic              flush_req,
    output logic              flush_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - SET_W;
    localparam int LINES  = SETS * WAYS;
    localparam int LINE_W = $clog2(LINES);

    typedef struct packed {
        state_t             st;
        logic               ready;
        logic [DATA_W-1:0]  rdata;
        logic               fdone;
        logic [LINE_W-1:0]  fidx;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [SET_W-1:0]             set_idx;
    logic [TAG_W-1:0]             req_tag;
    logic [WAYS-1:0]              rd_valid, rd_dirty;
    logic [WAYS-1:0][TAG_W-1:0]   rd_tag;
    logic [WAYS-1:0][DATA_W-1:0]  rd_data;
    logic [WAY_W-1:0]             rd_ptr, hit_way, wr_way;
    logic                         hit;
    logic                         fl_valid, fl_dirty;
    logic [TAG_W-1:0]             fl_tag;
    logic [DATA_W-1:0]            fl_data;
    logic                         wr_en, wr_dirty, ptr_adv, clr_all, step;
    logic [DATA_W-1:0]            wr_data;

    assign set_idx = cpu_addr[SET_W-1:0];
    assign req_tag = cpu_addr[ADDR_W-1:SET_W];

    cwb_line_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .rd_set(set_idx),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
        .rd_data(rd_data), .rd_ptr(rd_ptr),
        .fl_idx(c_q.fidx), .fl_valid(fl_valid), .fl_dirty(fl_dirty),
        .fl_tag(fl_tag), .fl_data(fl_data),
        .wr_en(wr_en), .wr_way(wr_way), .wr_dirty(wr_dirty),
        .wr_tag(req_tag), .wr_data(wr_data),
        .ptr_adv(ptr_adv), .clr_all(clr_all)
    );

    cwb_hit_find #(.WAYS(WAYS), .TAG_W(TAG_W)) u_hit (
        .valid(rd_valid), .tags(rd_tag), .key(req_tag),
        .hit(hit), .way(hit_way)
    );

    always_comb begin
        c_d       = c_q;
        c_d.ready = 1'b0;
        c_d.fdone = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        wr_en     = 1'b0;
        wr_way    = hit_way;
        wr_dirty  = 1'b1;
        wr_data   = cpu_wdata;
        ptr_adv   = 1'b0;
        clr_all   = 1'b0;
        step      = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (!c_q.ready && !c_q.fdone) begin
                    if (flush_req) begin
                        c_d.st   = ST_FLUSH;
                        c_d.fidx = '0;
                    end else if (cpu_req) begin
                        if (!cache_en) begin
                            c_d.st = ST_BYPASS;
                        end else if (hit) begin
                            c_d.ready = 1'b1;
                            c_d.rdata = cpu_we ? cpu_wdata : rd_data[hit_way];
                            wr_en     = cpu_we;
                        end else if (rd_valid[rd_ptr] && rd_dirty[rd_ptr]) begin
                            c_d.st = ST_EVICT;
                        end else begin
                            c_d.st = ST_FILL;
                        end
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rd_tag[rd_ptr], set_idx};
                mem_wdata = rd_data[rd_ptr];
                if (mem_ready) c_d.st = ST_FILL;
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = cpu_addr;
                if (mem_ready) begin
                    wr_en     = 1'b1;
                    wr_way    = rd_ptr;
                    wr_dirty  = cpu_we;
                    wr_data   = cpu_we ? cpu_wdata : mem_rdata;
                    ptr_adv   = 1'b1;
                    c_d.ready = 1'b1;
                    c_d.rdata = cpu_we ? cpu_wdata : mem_rdata;
                    c_d.st    = ST_IDLE;
                end
            end
            ST_BYPASS: begin
                mem_req   = 1'b1;
                mem_we    = cpu_we;
                mem_addr  = cpu_addr;
                mem_wdata = cpu_wdata;
                if (mem_ready) begin
                    c_d.ready = 1'b1;
                    c_d.rdata = cpu_we ? cpu_wdata : mem_rdata;
                    c_d.st    = ST_IDLE;
                end
            end
            ST_FLUSH: begin
                if (fl_valid && fl_dirty) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = {fl_tag, c_q.fidx[LINE_W-1 -: SET_W]};
                    mem_wdata = fl_data;
                    step      = mem_ready;
                end else begin
                    step = 1'b1;
                end
                if (step) begin
                    if (c_q.fidx == LINE_W'(LINES - 1)) begin
                        clr_all   = 1'b1;
                        c_d.fdone = 1'b1;
                        c_d.st    = ST_IDLE;
                    end else begin
                        c_d.fidx = c_q.fidx + 1'b1;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign cpu_ready  = c_q.ready;
    assign cpu_rdata  = c_q.rdata;
    assign flush_done = c_q.fdone;

endmodule

// File: rtl/cwb_checker.sv
module cwb_checker #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              flush_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready
);

    // R11
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req);

    // R11
    mem_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R11
    cpu_ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R9
    flush_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);

    // R10
    flush_cpu_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_done && cpu_ready));

endmodule

bind fifo_wb_cache cwb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .flush_done(flush_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/fifo_wb_cache_tb.sv
`timescale 1ns/1ps
module fifo_wb_cache_tb;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        cache_en = 1'b1, flush_req = 1'b0, flush_done;
    logic        mem_req, mem_we, mem_ready;
    logic [3:0]  mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    fifo_wb_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .cache_en(cache_en), .flush_req(flush_req),
        .flush_done(flush_done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata)
    );

    // Backing memory with a fixed latency and a log of every write
    logic [31:0] arr [16];
    int          lat_cnt;
    int          wcnt;
    int          wlog_a [256];
    int          wlog_d [256];

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
            lat_cnt   <= 0;
            wcnt      <= 0;
            for (int i = 0; i < 16; i++) arr[i] <= 32'h100 + i;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            lat_cnt   <= 0;
        end else if (mem_req) begin
            if (lat_cnt == LAT) begin
                mem_ready <= 1'b1;
                lat_cnt   <= 0;
                if (mem_we) begin
                    arr[mem_addr]  <= mem_wdata;
                    wlog_a[wcnt]   <= int'(mem_addr);
                    wlog_d[wcnt]   <= int'(mem_wdata);
                    wcnt           <= wcnt + 1;
                end else begin
                    mem_rdata <= arr[mem_addr];
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // Behavioural reference model
    typedef struct {int addr; int data; bit dirty; int way;} ent_t;
    ent_t fq [2][$];
    int   ptr [2];
    int   mv [16];
    int   exp_wa [$];
    int   exp_wd [$];
    int   consumed;
    int   checks, errors;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_access(bit we, int a, int wd, bit en, output int rd, output bit hit);
        int s;
        ent_t e, v;
        hit = 1'b0;
        rd  = 0;
        if (!en) begin
            if (we) begin
                mv[a] = wd;
                exp_wa.push_back(a);
                exp_wd.push_back(wd);
            end else begin
                rd = mv[a];
            end
            return;
        end
        s = a % 2;
        for (int i = 0; i < fq[s].size(); i++) begin
            if (fq[s][i].addr == a) begin
                hit = 1'b1;
                if (we) begin
                    fq[s][i].data  = wd;
                    fq[s][i].dirty = 1'b1;
                end
                rd = fq[s][i].data;
            end
        end
        if (!hit) begin
            if (fq[s].size() == 2) begin
                v = fq[s].pop_front();
                if (v.dirty) begin
                    exp_wa.push_back(v.addr);
                    exp_wd.push_back(v.data);
                    mv[v.addr] = v.data;
                end
            end
            e.addr  = a;
            e.way   = ptr[s];
            ptr[s]  = ptr[s] ^ 1;
            e.dirty = we;
            e.data  = we ? wd : mv[a];
            rd      = e.data;
            fq[s].push_back(e);
        end
    endtask

    task automatic model_flush();
        for (int s = 0; s < 2; s++)
            for (int w = 0; w < 2; w++)
                foreach (fq[s][i])
                    if (fq[s][i].way == w && fq[s][i].dirty) begin
                        exp_wa.push_back(fq[s][i].addr);
                        exp_wd.push_back(fq[s][i].data);
                        mv[fq[s][i].addr] = fq[s][i].data;
                    end
        fq[0].delete();
        fq[1].delete();
    endtask

    task automatic check_log(string req);
        while (exp_wa.size() > 0) begin
            int ea, ed;
            ea = exp_wa.pop_front();
            ed = exp_wd.pop_front();
            if (consumed < wcnt) begin
                chk(wlog_a[consumed] == ea, {req, " write-back address"}, wlog_a[consumed], ea);
                chk(wlog_d[consumed] == ed, {req, " write-back data"}, wlog_d[consumed], ed);
            end else begin
                chk(1'b0, {req, " missing memory write"}, wcnt, consumed + 1);
            end
            consumed++;
        end
        chk(consumed == wcnt, {req, " memory write count"}, wcnt, consumed);
        consumed = wcnt;
    endtask

    task automatic access(bit we, int a, int wd, bit en, string req);
        int  exp_rd, cyc;
        bit  hit;
        model_access(we, a, wd, en, exp_rd, hit);
        cache_en  = en;
        cpu_we    = we;
        cpu_addr  = 4'(a);
        cpu_wdata = wd;
        cpu_req   = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready);
        cpu_req = 1'b0;
        if (!we) chk(cpu_rdata == exp_rd, {req, " read data"}, cpu_rdata, exp_rd);
        if (hit) chk(cyc == 1, "R3 hit latency", cyc, 1);
        else if (en) chk(cyc > 1, {req, " miss goes to memory"}, cyc, 2);
        check_log(req);
        @(negedge clk);
        chk(!cpu_ready, "R11 cpu_ready single pulse", cpu_ready, 0);
    endtask

    task automatic do_flush();
        model_flush();
        flush_req = 1'b1;
        do @(negedge clk); while (!flush_done);
        flush_req = 1'b0;
        check_log("R9");
        @(negedge clk);
        chk(!flush_done, "R9 flush_done single pulse", flush_done, 0);
        for (int i = 0; i < 16; i++)
            chk(arr[i] == mv[i], "R9 memory after flush", arr[i], mv[i]);
    endtask

    task automatic collide(int a);
        int  exp_rd, cyc;
        bit  hit, seen_done;
        model_flush();
        model_access(1'b0, a, 0, 1'b1, exp_rd, hit);
        cache_en  = 1'b1;
        cpu_we    = 1'b0;
        cpu_addr  = 4'(a);
        cpu_req   = 1'b1;
        flush_req = 1'b1;
        seen_done = 1'b0;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (flush_done) begin
                seen_done = 1'b1;
                flush_req = 1'b0;
            end
            if (cpu_ready && !seen_done) chk(1'b0, "R10 request served before flush", 1, 0);
        end while (!cpu_ready);
        cpu_req = 1'b0;
        chk(seen_done, "R10 flush completed first", seen_done, 1);
        chk(!hit && cyc > 2, "R10 request misses after flush", cyc, 3);
        chk(cpu_rdata == exp_rd, "R10 read data after flush", cpu_rdata, exp_rd);
        check_log("R10");
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mv[i] = 32'h100 + i;
        ptr[0] = 0;
        ptr[1] = 0;
        consumed = 0;
        checks = 0;
        errors = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!cpu_ready, "R1 cpu_ready after reset", cpu_ready, 0);
        chk(!flush_done, "R1 flush_done after reset", flush_done, 0);
        chk(!mem_req, "R1 mem_req after reset", mem_req, 0);

        access(1'b0, 0, 0, 1'b1, "R1");          // first access misses
        access(1'b0, 0, 0, 1'b1, "R3");          // hit
        access(1'b0, 2, 0, 1'b1, "R2");          // second way of set 0
        access(1'b0, 0, 0, 1'b1, "R2");
        access(1'b0, 2, 0, 1'b1, "R2");
        access(1'b0, 0, 0, 1'b1, "R4");          // read hit keeps order
        access(1'b0, 4, 0, 1'b1, "R4");          // evicts address 0
        access(1'b0, 2, 0, 1'b1, "R4");          // still resident
        access(1'b0, 0, 0, 1'b1, "R4");          // refill, evicts 2
        access(1'b1, 4, 32'hA004, 1'b1, "R5");   // store hit, no memory write
        access(1'b0, 4, 0, 1'b1, "R5");
        access(1'b1, 1, 32'hB001, 1'b1, "R7");   // store miss allocates
        access(1'b0, 1, 0, 1'b1, "R7");
        access(1'b0, 6, 0, 1'b1, "R6");          // dirty victim 4 written back
        access(1'b0, 8, 0, 1'b1, "R6");          // clean victim 0, no write
        access(1'b1, 1, 32'hC001, 1'b0, "R8");   // bypass write over dirty line
        access(1'b0, 1, 0, 1'b0, "R8");          // bypass read sees memory
        access(1'b0, 1, 0, 1'b1, "R8");          // cached copy unchanged
        access(1'b1, 3, 32'hD003, 1'b1, "R7");
        access(1'b1, 6, 32'hE006, 1'b1, "R5");
        do_flush();
        access(1'b0, 1, 0, 1'b1, "R9");          // invalid after flush
        access(1'b1, 5, 32'hF005, 1'b1, "R7");
        access(1'b1, 2, 32'hF002, 1'b1, "R7");
        collide(5);
        access(1'b0, 2, 0, 1'b1, "R10");
        do_flush();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule